// File: doc/BRIEF.md
# SIMD Vector Merge and Permute Unit

This block rearranges the elements of 128-bit vectors. Given two source vectors A and B and an opcode, it can do three kinds of work. It can interleave the upper or lower halves of A and B, element by element, for 8-, 16- or 32-bit elements. It can widen the upper or lower half of B by sign extension, from bytes to half-words or from half-words to words. It can copy one element of B into every element position of the result. It sits after operand read in a vector execution pipe. It takes one operation per clock and returns each result exactly one clock later through a registered output stage.

Elements are numbered from the most significant end. For bytes, element 0 occupies bits 127:120. The "upper half" of an N-element vector is elements 0 to N/2-1.

Opcodes are 4 bits wide:

| Code | Operation |
|---|---|
| 0, 1, 2 | merge-high: byte, half-word, word |
| 3, 4, 5 | merge-low: byte, half-word, word |
| 6, 7 | unpack-high: byte, half-word |
| 8, 9 | unpack-low: byte, half-word |
| 10, 11, 12 | splat: byte, half-word, word |
| 13, 14, 15 | undefined |

Top module: `vec_merge_unit`

## Requirements
- R1: For opcodes 0/1/2 (8/16/32-bit merge-high), result element 2i equals A element i and result element 2i+1 equals B element i, for i = 0 to N/2-1, where N is the element count of the vector.
- R2: For opcodes 3/4/5 (8/16/32-bit merge-low), result element 2i equals A element N/2+i and result element 2i+1 equals B element N/2+i.
- R3: For opcodes 6/7, result element j (twice the source width) is B element j sign-extended, for j = 0 to N/2-1, with bytes for 6 and half-words for 7. For opcodes 8/9, it is B element N/2+j sign-extended.
- R4: For opcodes 10/11/12, every element of the result (8/16/32 bits wide) equals B element k. Here k is idx[3:0] for bytes, idx[2:0] for half-words and idx[1:0] for words; the unused upper idx bits have no effect.
- R5: For unpack and splat opcodes, src_a has no effect on the result.
- R6: out_valid equals in_valid delayed by exactly one clock. The result for inputs presented at edge k appears after edge k.
- R7: When out_valid is low, result is all zero and illegal is low.
- R8: Opcodes 13, 14 and 15 with in_valid high give an all-zero result with out_valid and illegal high for exactly that one output cycle.
- R9: Synchronous active-high rst clears out_valid, illegal and result at the next clock edge.
- R10: Operations issued on consecutive clocks each produce their own result, with no state carried from one to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| idx | input | 4 | Element index for splat |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | 128 | Registered result vector |
| illegal | output | 1 | Registered undefined-opcode flag |

## Verification
Two functions can fall in the same clock. While the output stage presents one operation's result, or its illegal flag, the next operation is already being computed and captured. The bench provokes this by streaming every opcode back to back with every idx value, inserting idle cycles and undefined opcodes between legal ones. It judges each output cycle against an arithmetic model of the operation issued one clock earlier, so any leakage between consecutive cycles shows up as a mismatch.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int VEC_W_DEF = 128;
  localparam int OP_W      = 4;
  localparam int IDX_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MH_B = 4'd0,  OP_MH_H = 4'd1,  OP_MH_W = 4'd2,
    OP_ML_B = 4'd3,  OP_ML_H = 4'd4,  OP_ML_W = 4'd5,
    OP_UH_B = 4'd6,  OP_UH_H = 4'd7,
    OP_UL_B = 4'd8,  OP_UL_H = 4'd9,
    OP_SP_B = 4'd10, OP_SP_H = 4'd11, OP_SP_W = 4'd12
  } vm_op_e;

  // Bit position of the top bit of lane 'lane' of width 'w' in a vector of 'vw' bits
  function automatic int lane_top(int vw, int lane, int w);
    return vw - 1 - lane * w;
  endfunction

  function automatic logic op_known(logic [OP_W-1:0] o);
    return o <= OP_SP_W;
  endfunction
endpackage

// File: rtl/vm_merge.sv
module vm_merge #(
  parameter int VEC_W = vm_pkg::VEC_W_DEF
) (
  input  logic [VEC_W-1:0]      a,
  input  logic [VEC_W-1:0]      b,
  output logic [2:0][VEC_W-1:0] hi_out,
  output logic [2:0][VEC_W-1:0] lo_out
);
  import vm_pkg::*;

  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W    = 8 << g;
    localparam int N    = VEC_W / W;
    localparam int HALF = N / 2;
    for (genvar i = 0; i < HALF; i++) begin : g_lane
      assign hi_out[g][lane_top(VEC_W, 2*i, W)   -: W] = a[lane_top(VEC_W, i, W) -: W];
      assign hi_out[g][lane_top(VEC_W, 2*i+1, W) -: W] = b[lane_top(VEC_W, i, W) -: W];
      assign lo_out[g][lane_top(VEC_W, 2*i, W)   -: W] = a[lane_top(VEC_W, HALF+i, W) -: W];
      assign lo_out[g][lane_top(VEC_W, 2*i+1, W) -: W] = b[lane_top(VEC_W, HALF+i, W) -: W];
    end
  end
endmodule

// File: rtl/vm_unpack.sv
module vm_unpack #(
  parameter int VEC_W = vm_pkg::VEC_W_DEF
) (
  input  logic [VEC_W-1:0]      b,
  output logic [1:0][VEC_W-1:0] hi_out,
  output logic [1:0][VEC_W-1:0] lo_out
);
  import vm_pkg::*;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W    = 8 << g;
    localparam int N    = VEC_W / W;
    localparam int HALF = N / 2;
    for (genvar j = 0; j < HALF; j++) begin : g_lane
      localparam int TH = lane_top(VEC_W, j, W);
      localparam int TL = lane_top(VEC_W, HALF + j, W);
      assign hi_out[g][lane_top(VEC_W, j, 2*W) -: 2*W] = {{W{b[TH]}}, b[TH -: W]};
      assign lo_out[g][lane_top(VEC_W, j, 2*W) -: 2*W] = {{W{b[TL]}}, b[TL -: W]};
    end
  end
endmodule

// File: rtl/vm_splat.sv
module vm_splat #(
  parameter int VEC_W = vm_pkg::VEC_W_DEF,
  parameter int IDX_W = vm_pkg::IDX_W
) (
  input  logic [VEC_W-1:0]      b,
  input  logic [IDX_W-1:0]      idx,
  output logic [2:0][VEC_W-1:0] sp_out
);
  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W  = 8 << g;
    localparam int N  = VEC_W / W;
    localparam int SB = $clog2(N);
    logic [SB-1:0]    sel;
    logic [VEC_W-1:0] shifted;
    logic [W-1:0]     elem;
    always_comb begin
      sel     = idx[SB-1:0];
      shifted = b << (int'(sel) * W);
      elem    = shifted[VEC_W-1 -: W];
    end
    assign sp_out[g] = {N{elem}};
  end
endmodule

// File: rtl/vec_merge_unit.sv
module vec_merge_unit #(
  parameter int VEC_W = vm_pkg::VEC_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [vm_pkg::OP_W-1:0]  op,
  input  logic [vm_pkg::IDX_W-1:0] idx,
  input  logic [VEC_W-1:0]         src_a,
  input  logic [VEC_W-1:0]         src_b,
  output logic                     out_valid,
  output logic [VEC_W-1:0]         result,
  output logic                     illegal
);
  import vm_pkg::*;

  logic [2:0][VEC_W-1:0] mrg_hi, mrg_lo, spl;
  logic [1:0][VEC_W-1:0] upk_hi, upk_lo;
  logic [VEC_W-1:0]      nxt_result;
  logic                  op_legal;
  logic                  nxt_illegal;

  vm_merge  #(.VEC_W(VEC_W)) u_merge  (.a(src_a), .b(src_b), .hi_out(mrg_hi), .lo_out(mrg_lo));
  vm_unpack #(.VEC_W(VEC_W)) u_unpack (.b(src_b), .hi_out(upk_hi), .lo_out(upk_lo));
  vm_splat  #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_splat (.b(src_b), .idx(idx), .sp_out(spl));

  assign op_legal    = op_known(op);
  assign nxt_illegal = in_valid && !op_legal;

  always_comb begin
    nxt_result = '0;
    case (op)
      OP_MH_B: nxt_result = mrg_hi[0];
      OP_MH_H: nxt_result = mrg_hi[1];
      OP_MH_W: nxt_result = mrg_hi[2];
      OP_ML_B: nxt_result = mrg_lo[0];
      OP_ML_H: nxt_result = mrg_lo[1];
      OP_ML_W: nxt_result = mrg_lo[2];
      OP_UH_B: nxt_result = upk_hi[0];
      OP_UH_H: nxt_result = upk_hi[1];
      OP_UL_B: nxt_result = upk_lo[0];
      OP_UL_H: nxt_result = upk_lo[1];
      OP_SP_B: nxt_result = spl[0];
      OP_SP_H: nxt_result = spl[1];
      OP_SP_W: nxt_result = spl[2];
      default: nxt_result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= nxt_illegal;
      result    <= in_valid ? nxt_result : '0;
    end
  end
endmodule

// File: rtl/vm_checker.sv
module vm_checker #(
  parameter int VEC_W = vm_pkg::VEC_W_DEF
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [vm_pkg::OP_W-1:0]  op,
  input logic [VEC_W-1:0]         src_a,
  input logic [VEC_W-1:0]         src_b,
  input logic                     out_valid,
  input logic [VEC_W-1:0]         result,
  input logic                     illegal
);
  import vm_pkg::*;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R6
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (result == '0 && !illegal));
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0 && out_valid));
  // R1
  merge_word_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_MH_W) |=>
      (result[VEC_W-1 -: 32] == $past(src_a[VEC_W-1 -: 32]) &&
       result[VEC_W-33 -: 32] == $past(src_b[VEC_W-1 -: 32])));
  // R4
  splat_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SP_W) |=>
      (result[VEC_W-1 -: 32] == result[31:0] && result[63:32] == result[31:0]));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && result == '0));
endmodule

bind vec_merge_unit vm_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
  .result(result), .illegal(illegal)
);

// File: tb/sim_vec_merge_unit.sv
`timescale 1ns/1ps
module sim_vec_merge_unit;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [3:0]    op;
  logic [3:0]    idx;
  logic [VW-1:0] src_a, src_b;
  logic          out_valid, illegal;
  logic [VW-1:0] result;

  int total = 0;
  int bad   = 0;

  logic          exp_v, exp_ill;
  logic [VW-1:0] exp_r;
  string         exp_tag;

  always #2.5 clk = ~clk;

  vec_merge_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .idx(idx),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  // element e (numbered from the top) of width w
  function automatic logic [63:0] pick(logic [VW-1:0] v, int e, int w);
    logic [VW-1:0] t;
    t = v >> (VW - (e + 1) * w);
    return 64'(t) & ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [VW-1:0] model(logic [3:0] o, logic [3:0] k,
                                          logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    int w, n, base;
    logic [63:0] e;
    if (o <= 4'd5) begin
      w = 8 * (1 << (o % 3)); n = VW / w;
      base = (o >= 4'd3) ? n / 2 : 0;
      for (int p = 0; p < n; p++) begin
        e = (p % 2 == 0) ? pick(a, base + p / 2, w) : pick(b, base + p / 2, w);
        r = (r << w) | VW'(e);
      end
    end else if (o <= 4'd9) begin
      w = (o == 4'd6 || o == 4'd8) ? 8 : 16; n = VW / w;
      base = (o >= 4'd8) ? n / 2 : 0;
      for (int p = 0; p < n / 2; p++) begin
        e = pick(b, base + p, w);
        if (e[w-1]) e = e | (((64'd1 << (2 * w)) - 64'd1) ^ ((64'd1 << w) - 64'd1));
        r = (r << (2 * w)) | VW'(e);
      end
    end else if (o <= 4'd12) begin
      w = 8 * (1 << (o - 4'd10)); n = VW / w;
      e = pick(b, int'(k) % n, w);
      for (int p = 0; p < n; p++) r = (r << w) | VW'(e);
    end
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] o);
    if (o <= 4'd2) return "R1";
    if (o <= 4'd5) return "R2";
    if (o <= 4'd9) return "R3";
    if (o <= 4'd12) return "R4";
    return "R8";
  endfunction

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // check the output stage against the pending expectation (R6/R7/R10)
  task automatic check_out();
    chk({exp_tag, "/R10"}, result, exp_r);
    chk("R6", VW'(out_valid), VW'(exp_v));
    chk(exp_v ? "R8" : "R7", VW'(illegal), VW'(exp_ill));
  endtask

  task automatic issue(logic v, logic [3:0] o, logic [3:0] k,
                       logic [VW-1:0] a, logic [VW-1:0] b);
    @(negedge clk);
    check_out();
    in_valid = v; op = o; idx = k; src_a = a; src_b = b;
    exp_v   = v;
    exp_ill = v && (o > 4'd12);
    exp_r   = v ? model(o, k, a, b) : '0;
    exp_tag = v ? tag_of(o) : "R7";
  endtask

  function automatic logic [VW-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 190000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] b0;
    rst = 1'b1; in_valid = 1'b1; op = 4'd0; idx = '0;
    src_a = '1; src_b = '1;
    exp_v = 1'b0; exp_ill = 1'b0; exp_r = '0; exp_tag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", result, '0);
    chk("R9", VW'(out_valid), '0);
    chk("R9", VW'(illegal), '0);
    rst = 1'b0; in_valid = 1'b0;

    // directed patterns: counting bytes, sign-heavy lanes
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 16; k++) begin
        issue(1'b1, 4'(o), 4'(k), VW'(128'h000102030405060708090a0b0c0d0e0f),
              VW'(128'hf0e1d2c3b4a5968778695a4b3c2d1e0f));
      end
    end
    // random sweep with idle gaps and back-to-back issue
    for (int rep = 0; rep < 40; rep++) begin
      for (int o = 0; o < 16; o++) begin
        issue(1'b1, 4'(o), 4'($urandom), rnd(), rnd());
        if ((rep + o) % 5 == 0) issue(1'b0, 4'(o), 4'd0, rnd(), rnd());
      end
    end
    // R5: src_a varied with fixed src_b on unpack/splat must not change result
    b0 = rnd();
    for (int o = 6; o <= 12; o++) begin
      for (int rep = 0; rep < 4; rep++) begin
        issue(1'b1, 4'(o), 4'(rep * 5), rep[0] ? '1 : '0, b0);
        exp_tag = "R5";
      end
    end
    // R8: undefined opcode directly after legal, then legal again
    issue(1'b1, 4'd2, 4'd0, rnd(), rnd());
    issue(1'b1, 4'd15, 4'd3, '1, '1);
    issue(1'b1, 4'd10, 4'd15, rnd(), rnd());
    issue(1'b0, 4'd0, 4'd0, '0, '0);
    // R9: reset mid-stream
    @(negedge clk);
    check_out();
    in_valid = 1'b1; op = 4'd0; src_a = '1; src_b = '1; rst = 1'b1;
    @(negedge clk);
    chk("R9", result, '0);
    chk("R9", VW'(out_valid), '0);
    rst = 1'b0; in_valid = 1'b0;
    exp_v = 1'b0; exp_ill = 1'b0; exp_r = '0; exp_tag = "R7";
    @(negedge clk);
    check_out();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule